// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block lets on-chip logic drive a three-wire serial EEPROM without handling the serial protocol itself. A client presents a command code, an address and write data, then pulses `start`. The controller selects the device with the serial clock low and shifts out one frame: a start bit, a two-bit opcode, the address field, and for data-carrying commands the data field. The serial clock is divided down from the system clock. Commands that need no address of their own (write enable, write disable, erase all, write all) share one opcode, and the command is told apart by the two top bits of the address field.

A read command discards the leading zero that the device sends before its data and then captures the data word. After a programming command (write, erase, erase all, write all) the controller deselects the device for a minimum time. It then selects it again and samples the device's data-out line, which reads 0 while the internal program cycle runs and 1 once it has finished. A busy timeout ends the poll with an error. The `org_x8` strap selects byte organisation (8-bit address, 8-bit data) or word organisation (7-bit address, 16-bit data).

The controller is a single state machine with six states. `ST_IDLE` waits for a request. `ST_SHIFT` sends the frame. `ST_RECV` reads the dummy bit and the data. `ST_DESEL` holds chip select low. `ST_POLL` samples the ready/busy line. `ST_FINISH` pulses `done`. The transitions are:
- `ST_IDLE` goes to `ST_SHIFT` on an accepted start, or to `ST_FINISH` on the reserved code.
- `ST_SHIFT` goes to `ST_RECV` for a read, to `ST_DESEL` for a programming command, or to `ST_FINISH` for enable or disable.
- `ST_RECV` goes to `ST_FINISH` once the word has been captured.
- `ST_DESEL` goes to `ST_POLL` once the deselect time has elapsed.
- `ST_POLL` goes to `ST_FINISH` when the device reports ready or the timeout expires.
- `ST_FINISH` always returns to `ST_IDLE`.

Top module: `ee3w_host`

## Requirements
- R1: After reset, `ee_cs`, `ee_sclk`, `ee_di`, `done` and `err` are all 0, and chip select is low whenever the controller is idle.
- R2: Every frame begins with chip select rising while the serial clock is low, followed by a start bit of 1 and a two-bit opcode: read 10, write 01, single erase 11, extended 00. `cmd` codes are 0 read, 1 write, 2 erase, 3 write enable, 4 write disable, 5 erase all, 6 write all.
- R3: Extended commands put a selector in the top two address-field bits (enable 11, disable 00, erase all 10, write all 01) and send every other address bit as 0.
- R4: With `org_x8`=0 the address field is `addr[6:0]` and the data field is `wdata[15:0]`. With `org_x8`=1 they are `addr[7:0]` and `wdata[7:0]`. Both fields are sent most significant bit first, and data is sent only for write and write all.
- R5: The serial clock toggles only while chip select is high, and each high phase lasts `CLK_DIV` system cycles. `ee_di` never changes while the serial clock is high.
- R6: On a read, the controller samples `ee_do` at each serial clock rising edge and discards the first sample, which is the dummy bit. `rdata` then holds the next 16 bits (x16), or the next 8 bits in `rdata[7:0]` with the upper bits 0 (x8).
- R7: After the last bit of a programming command, chip select stays low for at least `CS_LOW_CYC` system cycles and then rises again.
- R8: With chip select raised after programming, the controller keeps polling while `ee_do` is 0 and completes without error once it reads 1.
- R9: If the device has not reported ready after `BUSY_TICKS` poll samples, the command completes with `err`=1.
- R10: `done` is a one-cycle pulse with chip select low. A `start` that arrives while a command is in progress is ignored.
- R11: The reserved code `cmd`=7 completes at once with `done` and `err` and no bus activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted only in idle |
| cmd | input | 3 | Command code |
| org_x8 | input | 1 | 1 selects byte organisation, 0 word organisation |
| addr | input | ADDR_W+1 | Location address (x16 uses the low ADDR_W bits) |
| wdata | input | WORD_W | Write data (x8 uses the low half) |
| rdata | output | WORD_W | Data from the last read |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with done |
| ee_cs | output | 1 | Device chip select |
| ee_sclk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data / ready-busy from the device |

## Verification
A wrong state shows up in the next serial bit:
- If the bit counter or frame loader is off, a captured frame has the wrong length or content as soon as the command ends.
- If the read capture is off by the dummy bit, `rdata` comes back shifted by one position.
- If the deselect or poll state is skipped, chip select either rises too early or `done` arrives before the model device's program time has elapsed. The bench detects the first by measuring the low time and the second by counting cycles to `done`.

Protocol monitors run on every cycle and catch a data change during a clock high phase, or a wrong high-phase width, at the first edge where it occurs.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_ERASE = 3'd2,
        CMD_WEN   = 3'd3,
        CMD_WDIS  = 3'd4,
        CMD_ERALL = 3'd5,
        CMD_WRALL = 3'd6,
        CMD_RSVD  = 3'd7
    } ee3w_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_RECV,
        ST_DESEL,
        ST_POLL,
        ST_FINISH
    } ee3w_state_e;

endpackage

// File: rtl/ee3w_clkdiv.sv
module ee3w_clkdiv #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(HALF + 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ee3w_downcnt.sv
module ee3w_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] q;

    assign zero = (q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= val;
        end else if (dec && !zero) begin
            q <= q - 1'b1;
        end
    end

endmodule

// File: rtl/ee3w_framer.sv
module ee3w_framer
    import ee3w_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int WORD_W = 16,
    parameter int FR_W   = 4 + ADDR_W + WORD_W,
    parameter int LW     = $clog2(FR_W + 1)
) (
    input  ee3w_cmd_e         cmd,
    input  logic              org_x8,
    input  logic [ADDR_W:0]   addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [FR_W-1:0]   frame,
    output logic [LW-1:0]     len,
    output logic              is_read,
    output logic              is_prog
);
    localparam int BYTE_W = WORD_W / 2;

    logic [1:0]        op;
    logic [1:0]        ext;
    logic              ext_cmd;
    logic              has_data;
    logic [ADDR_W-1:0] afield16;
    logic [ADDR_W:0]   afield8;
    logic [LW-1:0]     alen;
    logic [LW-1:0]     dlen;

    always_comb begin
        op       = 2'b00;
        ext      = 2'b00;
        ext_cmd  = 1'b0;
        has_data = 1'b0;
        is_read  = 1'b0;
        is_prog  = 1'b0;
        unique case (cmd)
            CMD_READ:  begin op = 2'b10; is_read = 1'b1; end
            CMD_WRITE: begin op = 2'b01; has_data = 1'b1; is_prog = 1'b1; end
            CMD_ERASE: begin op = 2'b11; is_prog = 1'b1; end
            CMD_WEN:   begin ext_cmd = 1'b1; ext = 2'b11; end
            CMD_WDIS:  begin ext_cmd = 1'b1; ext = 2'b00; end
            CMD_ERALL: begin ext_cmd = 1'b1; ext = 2'b10; is_prog = 1'b1; end
            CMD_WRALL: begin ext_cmd = 1'b1; ext = 2'b01; has_data = 1'b1; is_prog = 1'b1; end
            CMD_RSVD:  begin op = 2'b00; end
        endcase
    end

    always_comb begin
        afield16 = ext_cmd ? {ext, {(ADDR_W-2){1'b0}}} : addr[ADDR_W-1:0];
        afield8  = ext_cmd ? {ext, {(ADDR_W-1){1'b0}}} : addr;
        if (org_x8) begin
            frame = {1'b1, op, afield8, wdata[BYTE_W-1:0], {BYTE_W{1'b0}}};
            alen  = LW'(ADDR_W + 1);
            dlen  = has_data ? LW'(BYTE_W) : '0;
        end else begin
            frame = {1'b1, op, afield16, wdata, 1'b0};
            alen  = LW'(ADDR_W);
            dlen  = has_data ? LW'(WORD_W) : '0;
        end
        len = LW'(3) + alen + dlen;
    end

endmodule

// File: rtl/ee3w_host.sv
module ee3w_host
    import ee3w_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int ADDR_W     = 7,
    parameter int WORD_W     = 16,
    parameter int CS_LOW_CYC = 50,
    parameter int BUSY_TICKS = 300000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cmd,
    input  logic              org_x8,
    input  logic [ADDR_W:0]   addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              done,
    output logic              err,
    output logic              ee_cs,
    output logic              ee_sclk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int BYTE_W = WORD_W / 2;
    localparam int FR_W   = 4 + ADDR_W + WORD_W;
    localparam int LW     = $clog2(FR_W + 1);
    localparam int RW     = $clog2(WORD_W + 2);
    localparam int DLW    = $clog2(CS_LOW_CYC + 1);
    localparam int TW     = $clog2(BUSY_TICKS + 1);

    ee3w_state_e       state_q, state_d;
    ee3w_cmd_e         cmd_e;
    logic [FR_W-1:0]   frame;
    logic [LW-1:0]     flen;
    logic              f_read, f_prog;

    logic [FR_W-1:0]   sh_q;
    logic [LW-1:0]     bitcnt_q;
    logic [RW-1:0]     rcnt_q;
    logic [WORD_W-1:0] rx_q;
    logic              org_q, is_read_q, is_prog_q, err_q;
    logic              cs_q, sclk_q, di_q;
    logic [WORD_W-1:0] rdata_q;
    logic [1:0]        do_sync_q;
    logic              do_s;

    logic              tick, clk_en;
    logic              del_load, del_zero;
    logic              to_load, to_dec, to_zero;
    logic              last_fall;

    assign cmd_e = ee3w_cmd_e'(cmd);
    assign do_s  = do_sync_q[1];

    ee3w_framer #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .FR_W   (FR_W),
        .LW     (LW)
    ) u_framer (
        .cmd     (cmd_e),
        .org_x8  (org_x8),
        .addr    (addr),
        .wdata   (wdata),
        .frame   (frame),
        .len     (flen),
        .is_read (f_read),
        .is_prog (f_prog)
    );

    assign clk_en = (state_q == ST_SHIFT) || (state_q == ST_RECV) || (state_q == ST_POLL);

    ee3w_clkdiv #(.HALF(CLK_DIV)) u_clkdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clk_en),
        .tick  (tick)
    );

    assign del_load = (state_q == ST_SHIFT) && (state_d == ST_DESEL);

    ee3w_downcnt #(.W(DLW)) u_desel_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (del_load),
        .val   (DLW'(CS_LOW_CYC)),
        .dec   (state_q == ST_DESEL),
        .zero  (del_zero)
    );

    assign to_load = (state_q == ST_DESEL) && (state_d == ST_POLL);
    assign to_dec  = (state_q == ST_POLL) && tick;

    ee3w_downcnt #(.W(TW)) u_busy_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (to_load),
        .val   (TW'(BUSY_TICKS)),
        .dec   (to_dec),
        .zero  (to_zero)
    );

    assign last_fall = tick && sclk_q && (bitcnt_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (cmd_e == CMD_RSVD) ? ST_FINISH : ST_SHIFT;
            end
            ST_SHIFT: begin
                if (last_fall) begin
                    if (is_read_q)      state_d = ST_RECV;
                    else if (is_prog_q) state_d = ST_DESEL;
                    else                state_d = ST_FINISH;
                end
            end
            ST_RECV: begin
                if (tick && sclk_q && (rcnt_q == '0)) state_d = ST_FINISH;
            end
            ST_DESEL: begin
                if (del_zero) state_d = ST_POLL;
            end
            ST_POLL: begin
                if (tick && (do_s || to_zero)) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            bitcnt_q  <= '0;
            rcnt_q    <= '0;
            rx_q      <= '0;
            org_q     <= 1'b0;
            is_read_q <= 1'b0;
            is_prog_q <= 1'b0;
            err_q     <= 1'b0;
            cs_q      <= 1'b0;
            sclk_q    <= 1'b0;
            di_q      <= 1'b0;
            rdata_q   <= '0;
            do_sync_q <= 2'b00;
        end else begin
            do_sync_q <= {do_sync_q[0], ee_do};
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (cmd_e == CMD_RSVD) begin
                            err_q <= 1'b1;
                        end else begin
                            err_q     <= 1'b0;
                            cs_q      <= 1'b1;
                            sh_q      <= frame;
                            di_q      <= frame[FR_W-1];
                            bitcnt_q  <= flen;
                            org_q     <= org_x8;
                            is_read_q <= f_read;
                            is_prog_q <= f_prog;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q   <= 1'b1;
                            bitcnt_q <= bitcnt_q - 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (bitcnt_q != '0) begin
                                sh_q <= sh_q << 1;
                                di_q <= sh_q[FR_W-2];
                            end else begin
                                di_q   <= 1'b0;
                                rcnt_q <= org_q ? RW'(BYTE_W + 1) : RW'(WORD_W + 1);
                                if (!is_read_q) cs_q <= 1'b0;
                            end
                        end
                    end
                end
                ST_RECV: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                            rx_q   <= {rx_q[WORD_W-2:0], do_s};
                            rcnt_q <= rcnt_q - 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (rcnt_q == '0) begin
                                cs_q    <= 1'b0;
                                rdata_q <= org_q ? {{(WORD_W-BYTE_W){1'b0}}, rx_q[BYTE_W-1:0]} : rx_q;
                            end
                        end
                    end
                end
                ST_DESEL: begin
                    if (del_zero) cs_q <= 1'b1;
                end
                ST_POLL: begin
                    if (tick && (do_s || to_zero)) begin
                        cs_q  <= 1'b0;
                        err_q <= !do_s;
                    end
                end
                ST_FINISH: begin
                    cs_q   <= 1'b0;
                    sclk_q <= 1'b0;
                end
                default: begin
                    cs_q <= 1'b0;
                end
            endcase
        end
    end

    assign ee_cs   = cs_q;
    assign ee_sclk = sclk_q;
    assign ee_di   = di_q;
    assign rdata   = rdata_q;
    assign done    = (state_q == ST_FINISH);
    assign err     = done && err_q;

    // checker state: length of the current chip-select low period
    logic [31:0] ast_cs_low_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       ast_cs_low_q <= '0;
        else if (cs_q)                    ast_cs_low_q <= '0;
        else if (ast_cs_low_q != '1)      ast_cs_low_q <= ast_cs_low_q + 1'b1;
    end

    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !ee_cs); // R1
    AST_CS_RISE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> !ee_sclk); // R2
    AST_CLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sclk); // R5
    AST_DI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sclk |-> $stable(ee_di)); // R5
    AST_DESEL_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ee_cs) && state_q == ST_POLL) |-> (ast_cs_low_q >= 32'(CS_LOW_CYC))); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_RSVD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && cmd == 3'd7) |=> (done && err && !ee_cs)); // R11

endmodule

// File: tb/test_ee3w_host.sv
`timescale 1ns/1ps
module test_ee3w_host;
    localparam int CLK_DIV    = 4;
    localparam int CS_LOW_CYC = 50;
    localparam int BUSY_TICKS = 200;
    localparam int PROG_CYC   = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic        org = 1'b0;
    logic [7:0]  addr = 8'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        done, err, ee_cs, ee_sclk, ee_di;
    logic        ee_do;

    always #2.5 clk = ~clk;

    ee3w_host #(
        .CLK_DIV(CLK_DIV), .ADDR_W(7), .WORD_W(16),
        .CS_LOW_CYC(CS_LOW_CYC), .BUSY_TICKS(BUSY_TICKS)
    ) i_ee3w_host (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .org_x8(org),
        .addr(addr), .wdata(wdata), .rdata(rdata), .done(done), .err(err),
        .ee_cs(ee_cs), .ee_sclk(ee_sclk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [7:0]  mem [256];
    logic [63:0] cap, last_cap;
    int          capn, last_n;
    bit          pcs, psclk, dreg, status, pend, wen, rd_mode, stuck;
    int          busy_left, rd_idx, m_op, m_a, m_ext;
    logic [15:0] rd_word;

    assign ee_do = status ? (busy_left == 0) : dreg;

    initial begin
        foreach (mem[i]) mem[i] = 8'h00;
        cap = '0; last_cap = '0; capn = 0; last_n = 0;
        pcs = 0; psclk = 0; dreg = 1; status = 0; pend = 0; wen = 0;
        rd_mode = 0; stuck = 0; busy_left = 0; rd_idx = 0;
        m_op = 0; m_a = 0; m_ext = 0; rd_word = '0;
    end

    always @(negedge clk) begin
        int aw, dw;
        aw = org ? 8 : 7;
        dw = org ? 8 : 16;
        if (ee_cs && !pcs) begin
            cap = '0; capn = 0; rd_mode = 0; dreg = 1;
        end
        if (!ee_cs && pcs) begin
            if (capn > 0) begin last_cap = cap; last_n = capn; end
            if (pend) begin
                status = 1;
                busy_left = stuck ? 1000000 : PROG_CYC;
            end else begin
                status = 0;
            end
            pend = 0;
        end else if (busy_left > 0) begin
            busy_left--;
        end
        if (ee_cs && ee_sclk && !psclk) begin
            cap = {cap[62:0], ee_di};
            capn++;
            if (capn == 3 + aw) begin
                m_op  = int'((cap >> aw) & 64'd3);
                m_a   = int'(cap & ((64'd1 << aw) - 1));
                m_ext = (m_a >> (aw - 2)) & 3;
                case (m_op)
                    2: begin
                        rd_word = org ? {8'h00, mem[m_a]} : {mem[2*m_a], mem[2*m_a+1]};
                        rd_idx = dw; dreg = 0; rd_mode = 1;
                    end
                    3: if (wen) begin
                        if (org) mem[m_a] = 8'hFF;
                        else begin mem[2*m_a] = 8'hFF; mem[2*m_a+1] = 8'hFF; end
                        pend = 1;
                    end
                    0: begin
                        if (m_ext == 3) wen = 1;
                        else if (m_ext == 0) wen = 0;
                        else if (m_ext == 2 && wen) begin
                            foreach (mem[i]) mem[i] = 8'hFF;
                            pend = 1;
                        end
                    end
                    default: ;
                endcase
            end else if (capn == 3 + aw + dw && (m_op == 1 || (m_op == 0 && m_ext == 1))) begin
                logic [15:0] d;
                int a2;
                d  = 16'(cap & ((64'd1 << dw) - 1));
                a2 = int'((cap >> dw) & ((64'd1 << aw) - 1));
                if (wen) begin
                    if (m_op == 1) begin
                        if (org) mem[a2] = d[7:0];
                        else begin mem[2*a2] = d[15:8]; mem[2*a2+1] = d[7:0]; end
                    end else begin
                        for (int i = 0; i < 256; i++)
                            mem[i] = org ? d[7:0] : ((i % 2 == 0) ? d[15:8] : d[7:0]);
                    end
                    pend = 1;
                end
            end else if (rd_mode && capn > 3 + aw && rd_idx > 0) begin
                rd_idx--;
                dreg = rd_word[rd_idx];
            end
        end
        pcs = ee_cs;
        psclk = ee_sclk;
    end

    // ---------------- protocol monitors ----------------
    int  viol_di = 0, viol_cs = 0, viol_per = 0, viol_done = 0, viol_idle = 0;
    int  cs_rises = 0, done_cnt = 0, hi_run = 0, low_run = 0, last_low = 0;
    bit  m_sclk = 0, m_di = 0, m_cs = 0, m_done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (m_sclk && ee_sclk && (ee_di != m_di)) viol_di++;
            if (ee_sclk && !ee_cs) viol_idle++;
            if (ee_cs && !m_cs) begin
                cs_rises++;
                if (ee_sclk) viol_cs++;
                last_low = low_run;
            end
            low_run = ee_cs ? 0 : low_run + 1;
            if (ee_sclk) hi_run++;
            else begin
                if (m_sclk && hi_run != CLK_DIV) viol_per++;
                hi_run = 0;
            end
            if (done) begin
                done_cnt++;
                if (m_done || ee_cs) viol_done++;
            end
        end
        m_sclk = ee_sclk; m_di = ee_di; m_cs = ee_cs; m_done = done;
    end

    // ---------------- helpers ----------------
    function automatic void exp_frame(input int c, input bit x8, input int a, input int d,
                                      output int n, output logic [63:0] v);
        int aw, dw, op, ext;
        bit is_ext, has_d;
        aw = x8 ? 8 : 7;
        dw = x8 ? 8 : 16;
        is_ext = 0; has_d = 0; op = 0; ext = 0;
        case (c)
            0: op = 2;
            1: begin op = 1; has_d = 1; end
            2: op = 3;
            3: begin is_ext = 1; ext = 3; end
            4: begin is_ext = 1; ext = 0; end
            5: begin is_ext = 1; ext = 2; end
            6: begin is_ext = 1; ext = 1; has_d = 1; end
            default: ;
        endcase
        v = 64'(4 + op);
        v = (v << aw) | (is_ext ? 64'(ext) << (aw - 2) : 64'(a) & ((64'd1 << aw) - 1));
        n = 3 + aw;
        if (has_d) begin
            v = (v << dw) | (64'(d) & ((64'd1 << dw) - 1));
            n += dw;
        end
    endfunction

    task automatic run_cmd(input int c, input bit x8, input int a, input int d,
                           output logic [15:0] rd, output logic e, output int cyc);
        @(negedge clk);
        cmd = 3'(c); org = x8; addr = 8'(a); wdata = 16'(d); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done, "R10", "command completes", 64'(done), 64'd1);
        rd = rdata;
        e = err;
        @(negedge clk);
    endtask

    task automatic chk_frame(input string req, input int c, input bit x8, input int a, input int d);
        int n;
        logic [63:0] v;
        exp_frame(c, x8, a, d, n, v);
        if (c == 0) begin
            int extra;
            extra = 1 + (x8 ? 8 : 16);
            chk(last_n == n + extra, req, "read frame bit count", 64'(last_n), 64'(n + extra));
            chk((last_cap >> extra) == v, req, "read frame header", last_cap >> extra, v);
        end else begin
            chk(last_n == n, req, "frame bit count", 64'(last_n), 64'(n));
            chk(last_cap == v, req, "frame content", last_cap, v);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(ee_cs == 0,   "R1", "cs after reset",   64'(ee_cs), 0);
        chk(ee_sclk == 0, "R1", "sclk after reset", 64'(ee_sclk), 0);
        chk(ee_di == 0,   "R1", "di after reset",   64'(ee_di), 0);
        chk(done == 0 && err == 0, "R1", "done/err after reset", 64'({done, err}), 0);
    endtask

    task automatic t_enable_write_read_x16();
        logic [15:0] rd; logic e; int cyc;
        run_cmd(3, 0, 0, 0, rd, e, cyc);
        chk_frame("R3", 3, 0, 0, 0);
        chk(e == 0, "R3", "enable no error", 64'(e), 0);
        run_cmd(1, 0, 8'h15, 16'hA5C3, rd, e, cyc);
        chk_frame("R4", 1, 0, 8'h15, 16'hA5C3);
        chk(last_low >= CS_LOW_CYC && last_low <= CS_LOW_CYC + 3, "R7", "deselect time",
            64'(last_low), 64'(CS_LOW_CYC));
        chk(cyc > PROG_CYC, "R8", "waited for ready", 64'(cyc), 64'(PROG_CYC));
        chk(e == 0, "R8", "write no error", 64'(e), 0);
        run_cmd(0, 0, 8'h15, 0, rd, e, cyc);
        chk_frame("R2", 0, 0, 8'h15, 0);
        chk(rd == 16'hA5C3, "R6", "x16 read data", 64'(rd), 64'hA5C3);
    endtask

    task automatic t_byte_mode();
        logic [15:0] rd; logic e; int cyc;
        run_cmd(1, 1, 8'hAB, 16'h775E, rd, e, cyc);
        chk_frame("R4", 1, 1, 8'hAB, 16'h775E);
        run_cmd(0, 1, 8'hAB, 0, rd, e, cyc);
        chk_frame("R4", 0, 1, 8'hAB, 0);
        chk(rd == 16'h005E, "R6", "x8 read data", 64'(rd), 64'h005E);
    endtask

    task automatic t_erase();
        logic [15:0] rd; logic e; int cyc;
        run_cmd(1, 0, 3, 16'h0102, rd, e, cyc);
        run_cmd(2, 0, 3, 0, rd, e, cyc);
        chk_frame("R2", 2, 0, 3, 0);
        run_cmd(0, 0, 3, 0, rd, e, cyc);
        chk(rd == 16'hFFFF, "R2", "erased word", 64'(rd), 64'hFFFF);
    endtask

    task automatic t_disable();
        logic [15:0] rd; logic e; int cyc;
        run_cmd(4, 0, 8'h7F, 0, rd, e, cyc);
        chk_frame("R3", 4, 0, 8'h7F, 0);
        run_cmd(1, 0, 8'h15, 16'h1111, rd, e, cyc);
        run_cmd(0, 0, 8'h15, 0, rd, e, cyc);
        chk(rd == 16'hA5C3, "R3", "disabled write kept data", 64'(rd), 64'hA5C3);
        run_cmd(3, 0, 0, 0, rd, e, cyc);
    endtask

    task automatic t_all();
        logic [15:0] rd; logic e; int cyc;
        run_cmd(6, 0, 8'h55, 16'h1234, rd, e, cyc);
        chk_frame("R3", 6, 0, 8'h55, 16'h1234);
        run_cmd(0, 0, 8'h7F, 0, rd, e, cyc);
        chk(rd == 16'h1234, "R3", "write-all data", 64'(rd), 64'h1234);
        run_cmd(5, 1, 8'h33, 0, rd, e, cyc);
        chk_frame("R3", 5, 1, 8'h33, 0);
        run_cmd(0, 0, 0, 0, rd, e, cyc);
        chk(rd == 16'hFFFF, "R3", "erase-all data", 64'(rd), 64'hFFFF);
    endtask

    task automatic t_timeout();
        logic [15:0] rd; logic e; int cyc;
        stuck = 1;
        run_cmd(1, 0, 8'h40, 16'hBEEF, rd, e, cyc);
        stuck = 0;
        chk(e == 1, "R9", "timeout error", 64'(e), 1);
        chk(cyc >= BUSY_TICKS * CLK_DIV, "R9", "timeout duration", 64'(cyc), 64'(BUSY_TICKS * CLK_DIV));
    endtask

    task automatic t_reserved();
        logic [15:0] rd; logic e; int cyc, r0;
        r0 = cs_rises;
        run_cmd(7, 0, 0, 0, rd, e, cyc);
        chk(e == 1, "R11", "reserved code error", 64'(e), 1);
        chk(cs_rises == r0, "R11", "no bus activity", 64'(cs_rises), 64'(r0));
    endtask

    task automatic t_busy_start();
        logic [15:0] rd; logic e; int cyc, d0;
        d0 = done_cnt;
        @(negedge clk);
        cmd = 3'd1; org = 0; addr = 8'h20; wdata = 16'h0F0F; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        cmd = 3'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        repeat (10) @(negedge clk);
        chk(done_cnt == d0 + 1, "R10", "single done for ignored start", 64'(done_cnt), 64'(d0 + 1));
        chk_frame("R10", 1, 0, 8'h20, 16'h0F0F);
        run_cmd(0, 0, 8'h20, 0, rd, e, cyc);
        chk(rd == 16'h0F0F, "R10", "data after ignored start", 64'(rd), 64'h0F0F);
    endtask

    task automatic finish_run();
        if (ended) return;
        ended = 1;
        chk(viol_di == 0,   "R5", "di changed while clock high", 64'(viol_di), 0);
        chk(viol_per == 0,  "R5", "clock high width",            64'(viol_per), 0);
        chk(viol_idle == 0, "R5", "clock while deselected",      64'(viol_idle), 0);
        chk(viol_cs == 0,   "R2", "select rose with clock high", 64'(viol_cs), 0);
        chk(viol_done == 0, "R10", "done width / cs at done",    64'(viol_done), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_enable_write_read_x16();
        t_byte_mode();
        t_erase();
        t_disable();
        t_all();
        t_timeout();
        t_reserved();
        t_busy_start();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule